// File: doc/BRIEF.md
# Hysteretic sync presence detector

This block decides whether an external horizontal sync signal is present. It judges every horizontal line period by whether a rising edge of `hsync` arrived during that period. It then counts consecutive lines whose outcome disagrees with the current verdict, and changes the verdict only when that run reaches a programmable length. The threshold for losing sync and the threshold for gaining it are set separately, so the hysteresis is programmable instead of being fixed by a single timeout. A short loss threshold gives fast dropout detection. A long acquisition threshold keeps a noisy input from being declared good too early.

The line period is marked in one of two ways, chosen by parameter. It can come from an external one-cycle `line_mark` strobe, or from an internal free-running counter that wraps every `LINE_CLKS` clocks and that `line_mark` can re-align. The two threshold codes are plain level inputs, registered inside the block, and are normally held static by the surrounding configuration logic. `hsync` is expected to be already synchronous to `clk`. The block has no streaming data path, so every pin is a plain control or status signal with no handshake.

Top module: `hsync_presence_det`

## Requirements
- R1: A synchronous reset forces `sync_ok` and `sync_chg` to 0, clears the run counter and zeroes both registered threshold codes. A run in progress before reset does not carry over after it.
- R2: A line counts as detected when `hsync` has a rising edge (low in one cycle, high in the next) in any cycle after the previous boundary up to and including the boundary cycle itself. If `hsync` is held high through a whole line with no rising edge, that line is a miss.
- R3: The loss threshold `loss_code` (bit 2 is the MSB) selects how many consecutive missed lines drop `sync_ok`: 000 gives the first missed line, 001 gives 4, 010 gives 8, and 1xx gives 16.
- R4: The acquisition threshold `acq_code` (bit 3 is the MSB) selects how many consecutive detected lines raise `sync_ok`: 0001 gives 32, 001x gives 64, 01xx gives 128, and 1xxx gives 256.
- R5: While `acq_code` is 0000, `sync_ok` never rises, however many lines are detected.
- R6: A line whose outcome agrees with the current verdict clears the run counter, so only consecutive disagreeing lines count.
- R7: `sync_ok` changes only on the clock edge that samples a line boundary. The new value is visible in the cycle after that edge.
- R8: `sync_chg` is high for exactly one cycle: the first cycle in which `sync_ok` shows its new value.
- R9: The run counter saturates at 256. While acquisition is disabled it keeps counting detected lines. If a nonzero `acq_code` is then applied, `sync_ok` rises on the next detected line.
- R10: With `EXT_LINE` = 0, a boundary occurs every `LINE_CLKS` clocks from the internal counter (and on `line_mark`, which restarts it). Steady `hsync` edges then raise the flag after the acquisition count of lines, and silence drops it after the loss count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| hsync | input | 1 | Horizontal sync pulse, synchronous to clk |
| line_mark | input | 1 | Line boundary strobe (external mode) or counter re-align (internal mode) |
| loss_code | input | 3 | Consecutive-miss threshold code |
| acq_code | input | 4 | Consecutive-hit threshold code, 0000 disables acquisition |
| sync_ok | output | 1 | Registered sync-present verdict |
| sync_chg | output | 1 | One-cycle pulse when sync_ok toggles |

## Verification
The verdict and the change pulse are due one clock after the edge that samples the boundary strobe. Every line task therefore raises the strobe at a falling edge, lets one rising edge pass, and samples both outputs at the next falling edge. One check samples just before that edge to show the flag has not yet moved. A code change takes effect one edge after it is driven, so each scenario applies its codes at least a full cycle before its first line boundary. In internal-timer mode the exact boundary phase is not tracked. Those checks are placed several line periods away from either edge of the expected window, so they do not depend on phase.

// File: rtl/hsd_pkg.sv
package hsd_pkg;
  localparam int RUN_MAX = 256;
  localparam int CNT_W   = $clog2(RUN_MAX + 1);

  typedef logic [CNT_W-1:0] run_t;

  // consecutive misses needed to drop the verdict
  function automatic run_t loss_lines(input logic [2:0] code);
    if (code[2])      return run_t'(16);
    else if (code[1]) return run_t'(8);
    else if (code[0]) return run_t'(4);
    else              return run_t'(0);
  endfunction

  // consecutive hits needed to raise the verdict; 0 means disabled
  function automatic run_t acq_lines(input logic [3:0] code);
    if (code[3])      return run_t'(256);
    else if (code[2]) return run_t'(128);
    else if (code[1]) return run_t'(64);
    else if (code[0]) return run_t'(32);
    else              return run_t'(0);
  endfunction
endpackage

// File: rtl/hsd_line_timer.sv
module hsd_line_timer #(
  parameter int LINE_CLKS = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic realign,
  output logic tick
);
  localparam int TW = (LINE_CLKS > 2) ? $clog2(LINE_CLKS) : 1;
  localparam logic [TW-1:0] LAST = TW'(LINE_CLKS - 1);

  logic [TW-1:0] cnt;

  assign tick = realign || (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst || tick) cnt <= '0;
    else             cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/hsd_edge_window.sv
module hsd_edge_window (
  input  logic clk,
  input  logic rst,
  input  logic hsync,
  input  logic tick,
  output logic hit
);
  logic hs_q;
  logic seen;
  logic rise;

  assign rise = hsync && !hs_q;
  assign hit  = seen || rise;

  always_ff @(posedge clk) begin
    if (rst) begin
      hs_q <= 1'b0;
      seen <= 1'b0;
    end else begin
      hs_q <= hsync;
      seen <= tick ? 1'b0 : (seen || rise);
    end
  end
endmodule

// File: rtl/hsd_streak.sv
module hsd_streak
  import hsd_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic hit,
  input  run_t thr_loss,
  input  run_t thr_acq,
  output logic flag,
  output logic chg,
  output run_t run_cnt
);
  run_t nxt;

  assign nxt = (run_cnt == run_t'(RUN_MAX)) ? run_cnt : run_cnt + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      flag    <= 1'b0;
      chg     <= 1'b0;
      run_cnt <= '0;
    end else begin
      chg <= 1'b0;
      if (tick) begin
        if (flag == hit) begin
          run_cnt <= '0;
        end else if (flag) begin
          if (nxt >= thr_loss) begin
            flag    <= 1'b0;
            chg     <= 1'b1;
            run_cnt <= '0;
          end else begin
            run_cnt <= nxt;
          end
        end else begin
          if (thr_acq != '0 && nxt >= thr_acq) begin
            flag    <= 1'b1;
            chg     <= 1'b1;
            run_cnt <= '0;
          end else begin
            run_cnt <= nxt;
          end
        end
      end
    end
  end
endmodule

// File: rtl/hsync_presence_det.sv
module hsync_presence_det
  import hsd_pkg::*;
#(
  parameter int EXT_LINE  = 1,
  parameter int LINE_CLKS = 64
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       hsync,
  input  logic       line_mark,
  input  logic [2:0] loss_code,
  input  logic [3:0] acq_code,
  output logic       sync_ok,
  output logic       sync_chg
);
  logic [2:0] loss_q;
  logic [3:0] acq_q;
  logic       line_tick;
  logic       tmr_tick;
  logic       tmr_realign;
  logic       line_hit;
  run_t       run_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      loss_q <= '0;
      acq_q  <= '0;
    end else begin
      loss_q <= loss_code;
      acq_q  <= acq_code;
    end
  end

  generate
    if (EXT_LINE != 0) begin : g_ext
      assign tmr_realign = 1'b0;
      assign line_tick   = line_mark;
    end else begin : g_int
      assign tmr_realign = line_mark;
      assign line_tick   = tmr_tick;
    end
  endgenerate

  hsd_line_timer #(.LINE_CLKS(LINE_CLKS)) u_tmr (
    .clk    (clk),
    .rst    (rst),
    .realign(tmr_realign),
    .tick   (tmr_tick)
  );

  hsd_edge_window u_win (
    .clk  (clk),
    .rst  (rst),
    .hsync(hsync),
    .tick (line_tick),
    .hit  (line_hit)
  );

  hsd_streak u_run (
    .clk     (clk),
    .rst     (rst),
    .tick    (line_tick),
    .hit     (line_hit),
    .thr_loss(loss_lines(loss_q)),
    .thr_acq (acq_lines(acq_q)),
    .flag    (sync_ok),
    .chg     (sync_chg),
    .run_cnt (run_cnt)
  );
endmodule

// File: rtl/hsd_chk.sv
module hsd_chk
  import hsd_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic       tick,
  input logic       hit,
  input logic       flag,
  input logic       chg,
  input logic [3:0] acq_q,
  input run_t       run_cnt
);
  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!flag && !chg && run_cnt == '0));

  // R2
  rise_needs_hit_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(flag) |-> $past(hit));

  // R2
  fall_needs_miss_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(flag) |-> !$past(hit));

  // R5
  no_rise_disabled_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(flag) |-> ($past(acq_q) != 4'd0));

  // R7
  flag_on_tick_chk: assert property (@(posedge clk) disable iff (rst)
    (flag != $past(flag)) |-> $past(tick));

  // R8
  chg_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    chg == (flag != $past(flag)));

  // R9
  run_cap_chk: assert property (@(posedge clk) disable iff (rst)
    run_cnt <= run_t'(RUN_MAX));
endmodule

bind hsync_presence_det hsd_chk u_chk (
  .clk    (clk),
  .rst    (rst),
  .tick   (line_tick),
  .hit    (line_hit),
  .flag   (sync_ok),
  .chg    (sync_chg),
  .acq_q  (acq_q),
  .run_cnt(run_cnt)
);

// File: tb/sim_hsync_presence_det.sv
module sim_hsync_presence_det;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       hsync = 1'b0;
  logic       line_end = 1'b0;
  logic [2:0] loss_c = 3'd0;
  logic [3:0] acq_c = 4'd0;
  logic       ok, chg;

  logic       hs1 = 1'b0;
  logic       hs1_en = 1'b0;
  logic       ok1, chg1;

  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  hsync_presence_det #(.EXT_LINE(1)) u0 (
    .clk(clk), .rst(rst), .hsync(hsync), .line_mark(line_end),
    .loss_code(loss_c), .acq_code(acq_c), .sync_ok(ok), .sync_chg(chg)
  );

  hsync_presence_det #(.EXT_LINE(0), .LINE_CLKS(8)) u1 (
    .clk(clk), .rst(rst), .hsync(hs1), .line_mark(1'b0),
    .loss_code(3'd0), .acq_code(4'd1), .sync_ok(ok1), .sync_chg(chg1)
  );

  always @(posedge clk) hs1 <= hs1_en ? ~hs1 : 1'b0;

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0b expected %0b", req, act, exp);
    end
  endtask

  // kind: 0 miss, 1 mid-line pulse, 2 rise on boundary cycle, 3 held high
  task automatic line_open(input int kind);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      line_end = 1'b0;
      if (kind == 1)      hsync = (i == 2 || i == 3);
      else if (kind == 3) hsync = 1'b1;
      else                hsync = 1'b0;
    end
    @(negedge clk);
    line_end = 1'b1;
    if (kind == 2) hsync = 1'b1;
  endtask

  task automatic line_close();
    @(negedge clk);
    line_end = 1'b0;
  endtask

  task automatic lines(input int kind, input int n);
    for (int i = 0; i < n; i++) begin
      line_open(kind);
      line_close();
    end
  endtask

  task automatic set_codes(input logic [2:0] l, input logic [3:0] a);
    @(negedge clk);
    loss_c = l;
    acq_c  = a;
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 ok after reset", ok, 1'b0);
    chk("R1 chg after reset", chg, 1'b0);
  endtask

  task automatic t_disabled();
    set_codes(3'b000, 4'b0000);
    lines(1, 40);
    chk("R5 no rise with acq 0000", ok, 1'b0);
  endtask

  task automatic t_saturate();
    lines(1, 260);
    chk("R5 still absent after 300 hits", ok, 1'b0);
    set_codes(3'b000, 4'b0001);
    lines(1, 1);
    chk("R9 rise on first hit after enabling", ok, 1'b1);
    chk("R8 chg high on toggle", chg, 1'b1);
    @(negedge clk);
    chk("R8 chg one cycle only", chg, 1'b0);
  endtask

  task automatic t_loss4();
    set_codes(3'b001, 4'b0001);
    lines(0, 3);
    chk("R3 still present after 3 misses", ok, 1'b1);
    lines(1, 1);
    lines(0, 3);
    chk("R6 hit restarts miss run", ok, 1'b1);
    lines(0, 1);
    chk("R3 drop after 4 misses", ok, 1'b0);
    chk("R8 chg on drop", chg, 1'b1);
  endtask

  task automatic t_acq32();
    lines(1, 31);
    chk("R4 absent after 31 hits", ok, 1'b0);
    lines(0, 1);
    lines(1, 31);
    chk("R6 miss restarts hit run", ok, 1'b0);
    lines(1, 1);
    chk("R4 rise after 32 hits", ok, 1'b1);
  endtask

  task automatic t_loss0();
    set_codes(3'b000, 4'b0011);
    lines(0, 1);
    chk("R3 code 000 drops on first miss", ok, 1'b0);
  endtask

  task automatic t_acq64();
    lines(1, 63);
    chk("R4 absent after 63 hits", ok, 1'b0);
    line_open(1);
    chk("R7 flag steady before boundary edge", ok, 1'b0);
    line_close();
    chk("R7 flag new value after boundary edge", ok, 1'b1);
  endtask

  task automatic t_loss16();
    set_codes(3'b101, 4'b0110);
    lines(0, 15);
    chk("R3 present after 15 misses", ok, 1'b1);
    lines(0, 1);
    chk("R3 drop after 16 misses", ok, 1'b0);
  endtask

  task automatic t_acq128();
    lines(1, 127);
    chk("R4 absent after 127 hits", ok, 1'b0);
    lines(1, 1);
    chk("R4 rise after 128 hits", ok, 1'b1);
  endtask

  task automatic t_loss8();
    set_codes(3'b010, 4'b1001);
    lines(0, 7);
    chk("R3 present after 7 misses", ok, 1'b1);
    lines(0, 1);
    chk("R3 drop after 8 misses", ok, 1'b0);
  endtask

  task automatic t_acq256();
    lines(1, 255);
    chk("R4 absent after 255 hits", ok, 1'b0);
    lines(1, 1);
    chk("R4 rise after 256 hits", ok, 1'b1);
  endtask

  task automatic t_edges();
    set_codes(3'b000, 4'b0001);
    lines(2, 1);
    chk("R2 rise on boundary cycle counts as hit", ok, 1'b1);
    lines(3, 1);
    chk("R2 held-high line is a miss", ok, 1'b0);
    lines(2, 31);
    chk("R2 absent after 31 boundary-edge hits", ok, 1'b0);
    lines(2, 1);
    chk("R2 rise after 32 boundary-edge hits", ok, 1'b1);
    lines(0, 1);
  endtask

  task automatic t_reset_mid();
    lines(1, 20);
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    chk("R1 ok cleared by reset", ok, 1'b0);
    chk("R1 chg cleared by reset", chg, 1'b0);
    @(negedge clk);
    lines(1, 20);
    chk("R1 run did not carry over reset", ok, 1'b0);
    lines(1, 12);
    chk("R1 rise after 32 post-reset hits", ok, 1'b1);
  endtask

  task automatic t_timer();
    @(negedge clk);
    hs1_en = 1'b1;
    repeat (30 * 8) @(negedge clk);
    chk("R10 internal timer absent before 32 lines", ok1, 1'b0);
    repeat (6 * 8) @(negedge clk);
    chk("R10 internal timer present after 36 lines", ok1, 1'b1);
    hs1_en = 1'b0;
    repeat (3 * 8) @(negedge clk);
    chk("R10 internal timer drop after silence", ok1, 1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog (all): got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_disabled();
    t_saturate();
    t_loss4();
    t_acq32();
    t_loss0();
    t_acq64();
    t_loss16();
    t_acq128();
    t_loss8();
    t_acq256();
    t_edges();
    t_reset_mid();
    t_timer();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule